// File: doc/BRIEF.md
# MAC Address Table Host Access Engine

This block holds a small table of Ethernet MAC addresses and gives a host processor full control of it through a plain synchronous register port. Each slot keeps a 48-bit address, a valid flag, a static flag and a 2-bit port number. The host loads an entry into two staging registers. It then sets a command bit to insert, change or remove that entry, and watches a busy flag until the operation is over.

The same command register starts a walk over the table. A "first" command begins at slot 0 and a "next" command carries on after the last slot returned. The walk engine skips empty slots and places the next occupied entry in two result registers, together with a valid flag, or an end-of-table flag when no occupied slot remains. Commands act on the rising edge of their bit, so the host writes a command value and then clears it with a write of zero.

Top module: `mac_tbl_host`

## Requirements
- R1: After a synchronous reset, every readable register (addresses 0 to 7) reads zero and the table holds no valid entry.
- R2: Address 0 stores staging MAC bits [31:0]. Address 1 stores a 32-bit word holding MAC bits [47:32] in [15:0], the port in [17:16], static in [18] and valid in [19]. Both read back exactly as written.
- R3: A rising edge on command bit 2 (address 2) starts a make operation. Status bit 0 (address 3) reads 1 for exactly DEPTH+1 cycles, starting with the cycle after the command write.
- R4: A make whose MAC equals that of a valid slot overwrites that slot in place with the staged port, static and valid values.
- R5: A make with a MAC that no valid slot has and with valid=1 fills the lowest-numbered free slot. With valid=0, nothing is inserted.
- R6: A make with valid=0 and static=0 whose MAC matches a valid slot removes that entry.
- R7: When all DEPTH slots are valid, a make with a new MAC completes with the table unchanged.
- R8: A rising edge on command bit 1 clears the result registers and scans from slot 0. On a hit, address 4 holds MAC[31:0], and address 5 holds MAC[47:32] in [15:0], port in [17:16], static in [18] and valid=1 in [19]. Valid and end-of-table are never set together.
- R9: A rising edge on command bit 0 scans from the slot after the last one returned. The scan tests one slot per clock. When no valid slot remains, address 5 reads only the end-of-table bit [20] set. While a scan runs, status bit 1 reads 1.
- R10: A command edge that arrives while a make or a scan is in progress is ignored.
- R11: Commands act only on a 0-to-1 change of a command bit, so rewriting a held value starts nothing. When bits rise together, make wins over first, and first wins over next. The command register reads back its low 3 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |

## Verification
The hardest state to reach from the ports is a completely full table, which the full-table rule depends on. To get there, the stimulus issues dozens of make commands with distinct addresses, waits for each to finish, and then tries one more insertion and walks all slots. Removal followed by re-insertion is exercised to show that a freed low slot is reused ahead of higher free slots. Simultaneous and held command bits are written to check edge detection and priority.

// File: rtl/mac_tbl_pkg.sv
package mac_tbl_pkg;

    localparam int MAC_W  = 48;
    localparam int PORT_W = 2;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 3;

    // register map
    localparam logic [ADDR_W-1:0] A_WLO = 3'd0;
    localparam logic [ADDR_W-1:0] A_WHI = 3'd1;
    localparam logic [ADDR_W-1:0] A_CMD = 3'd2;
    localparam logic [ADDR_W-1:0] A_STS = 3'd3;
    localparam logic [ADDR_W-1:0] A_RLO = 3'd4;
    localparam logic [ADDR_W-1:0] A_RHI = 3'd5;

    // command bits
    localparam int CB_NEXT  = 0;
    localparam int CB_FIRST = 1;
    localparam int CB_MAKE  = 2;

    typedef struct packed {
        logic [MAC_W-1:0]  mac;
        logic [PORT_W-1:0] port;
        logic              stat;
        logic              vld;
    } ent_t;

    typedef enum logic [1:0] {MK_IDLE, MK_SCAN, MK_WRITE} mk_st_t;

    function automatic ent_t unpack_stage(logic [DATA_W-1:0] lo, logic [DATA_W-1:0] hi);
        ent_t e;
        e.mac  = {hi[15:0], lo};
        e.port = hi[17:16];
        e.stat = hi[18];
        e.vld  = hi[19];
        return e;
    endfunction

    function automatic logic [DATA_W-1:0] pack_result(ent_t e, logic eot);
        return {11'b0, eot, e.vld, e.stat, e.port, e.mac[47:32]};
    endfunction

endpackage

// File: rtl/mac_tbl_regs.sv
module mac_tbl_regs
    import mac_tbl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              busy,
    output logic [DATA_W-1:0] stage_lo,
    output logic [DATA_W-1:0] stage_hi,
    output logic [2:0]        cmd_q,
    output logic              make_go,
    output logic              first_go,
    output logic              next_go
);

    logic [2:0] rise;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_lo <= '0;
            stage_hi <= '0;
            cmd_q    <= '0;
        end else if (wr) begin
            case (addr)
                A_WLO:   stage_lo <= wdata;
                A_WHI:   stage_hi <= wdata;
                A_CMD:   cmd_q    <= wdata[2:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        rise = '0;
        if (wr && addr == A_CMD && !busy)
            rise = wdata[2:0] & ~cmd_q;
        make_go  = rise[CB_MAKE];
        first_go = rise[CB_FIRST] & ~rise[CB_MAKE];
        next_go  = rise[CB_NEXT] & ~rise[CB_FIRST] & ~rise[CB_MAKE];
    end

    // R11
    go_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({make_go, first_go, next_go}));

endmodule

// File: rtl/mac_tbl_store.sv
module mac_tbl_store
    import mac_tbl_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int IW = $clog2(DEPTH)
)(
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  ent_t          new_ent,
    input  logic [IW-1:0] rd_idx,
    output ent_t          rd_ent,
    output logic          pending
);

    ent_t           tbl [DEPTH];
    mk_st_t         state;
    ent_t           op;
    logic [IW-1:0]  sidx;
    logic           match_q, free_q;
    logic [IW-1:0]  match_idx, free_idx;
    logic [DEPTH-1:0] vld_vec;

    for (genvar g = 0; g < DEPTH; g++) begin : g_vld
        assign vld_vec[g] = tbl[g].vld;
    end

    assign rd_ent  = tbl[rd_idx];
    assign pending = (state != MK_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) tbl[i] <= '0;
            state     <= MK_IDLE;
            op        <= '0;
            sidx      <= '0;
            match_q   <= 1'b0;
            free_q    <= 1'b0;
            match_idx <= '0;
            free_idx  <= '0;
        end else begin
            case (state)
                MK_IDLE: if (start) begin
                    op      <= new_ent;
                    sidx    <= '0;
                    match_q <= 1'b0;
                    free_q  <= 1'b0;
                    state   <= MK_SCAN;
                end
                MK_SCAN: begin
                    if (tbl[sidx].vld && tbl[sidx].mac == op.mac && !match_q) begin
                        match_q   <= 1'b1;
                        match_idx <= sidx;
                    end
                    if (!tbl[sidx].vld && !free_q) begin
                        free_q   <= 1'b1;
                        free_idx <= sidx;
                    end
                    if (sidx == IW'(DEPTH - 1)) state <= MK_WRITE;
                    else                        sidx  <= sidx + 1'b1;
                end
                MK_WRITE: begin
                    if (match_q)
                        tbl[match_idx] <= op;
                    else if (free_q && op.vld)
                        tbl[free_idx] <= op;
                    state <= MK_IDLE;
                end
                default: state <= MK_IDLE;
            endcase
        end
    end

    // R10
    start_idle_chk: assert property (@(posedge clk) disable iff (rst)
        start |-> state == MK_IDLE);

    // R7
    full_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (state == MK_WRITE && !match_q && !free_q) |=> $stable(vld_vec));

    // R4
    modify_count_chk: assert property (@(posedge clk) disable iff (rst)
        (state == MK_WRITE && match_q && op.vld) |=>
            $countones(vld_vec) == $past($countones(vld_vec)));

    // R6
    delete_count_chk: assert property (@(posedge clk) disable iff (rst)
        (state == MK_WRITE && match_q && !op.vld) |=>
            $countones(vld_vec) + 1 == $past($countones(vld_vec)));

endmodule

// File: rtl/mac_tbl_scan.sv
module mac_tbl_scan
    import mac_tbl_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int IW = $clog2(DEPTH),
    localparam int CW = IW + 1
)(
    input  logic          clk,
    input  logic          rst,
    input  logic          first_go,
    input  logic          next_go,
    input  ent_t          cur_ent,
    output logic [IW-1:0] idx,
    output logic          busy,
    output ent_t          res,
    output logic          eot
);

    logic [CW-1:0] widx;
    logic [CW-1:0] cursor;
    logic          walking;

    assign idx  = widx[IW-1:0];
    assign busy = walking;

    always_ff @(posedge clk) begin
        if (rst) begin
            widx    <= '0;
            cursor  <= '0;
            walking <= 1'b0;
            res     <= '0;
            eot     <= 1'b0;
        end else if (first_go || next_go) begin
            widx    <= first_go ? '0 : cursor;
            walking <= 1'b1;
            res     <= '0;
            eot     <= 1'b0;
        end else if (walking) begin
            if (widx == CW'(DEPTH)) begin
                eot     <= 1'b1;
                cursor  <= CW'(DEPTH);
                walking <= 1'b0;
            end else if (cur_ent.vld) begin
                res     <= cur_ent;
                cursor  <= widx + 1'b1;
                walking <= 1'b0;
            end else begin
                widx <= widx + 1'b1;
            end
        end
    end

    // R8
    flags_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(res.vld && eot));

    // R9
    end_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (walking && !first_go && !next_go && widx == CW'(DEPTH)) |=> (eot && !res.vld && !walking));

endmodule

// File: rtl/mac_tbl_host.sv
module mac_tbl_host
    import mac_tbl_pkg::*;
#(
    parameter int DEPTH = 64
)(
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata
);

    localparam int IW = $clog2(DEPTH);

    logic [DATA_W-1:0] stage_lo, stage_hi;
    logic [2:0]        cmd_q;
    logic              make_go, first_go, next_go;
    logic              pending, scan_busy, eot;
    logic [IW-1:0]     scan_idx;
    ent_t              scan_ent, res;

    mac_tbl_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr       (reg_wr),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .busy     (pending | scan_busy),
        .stage_lo (stage_lo),
        .stage_hi (stage_hi),
        .cmd_q    (cmd_q),
        .make_go  (make_go),
        .first_go (first_go),
        .next_go  (next_go)
    );

    mac_tbl_store #(.DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .rst     (rst),
        .start   (make_go),
        .new_ent (unpack_stage(stage_lo, stage_hi)),
        .rd_idx  (scan_idx),
        .rd_ent  (scan_ent),
        .pending (pending)
    );

    mac_tbl_scan #(.DEPTH(DEPTH)) u_scan (
        .clk      (clk),
        .rst      (rst),
        .first_go (first_go),
        .next_go  (next_go),
        .cur_ent  (scan_ent),
        .idx      (scan_idx),
        .busy     (scan_busy),
        .res      (res),
        .eot      (eot)
    );

    always_comb begin
        case (reg_addr)
            A_WLO:   reg_rdata = stage_lo;
            A_WHI:   reg_rdata = stage_hi;
            A_CMD:   reg_rdata = {29'b0, cmd_q};
            A_STS:   reg_rdata = {30'b0, scan_busy, pending};
            A_RLO:   reg_rdata = res.mac[31:0];
            A_RHI:   reg_rdata = pack_result(res, eot);
            default: reg_rdata = '0;
        endcase
    end

    // R10
    no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
        !(pending && scan_busy));

endmodule

// File: tb/test_mac_tbl_host.sv
`timescale 1ns/1ps
module test_mac_tbl_host;

    localparam int N = 64;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    mac_tbl_host #(.DEPTH(N)) i_mac_tbl_host (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    // ---------------- behavioural reference model ----------------
    logic [47:0] t_mac [N];
    logic [1:0]  t_port[N];
    bit          t_st  [N];
    bit          t_v   [N];
    logic [31:0] m_wlo, m_whi, m_rlo, m_rhi;
    logic [2:0]  m_cmd;
    int          mk_cnt, sc_cnt, sc_tgt, m_cursor;
    logic [31:0] op_lo, op_hi;
    bit          started = 0;

    task automatic model_make();
        logic [47:0] mac;
        int hit;
        mac = {op_hi[15:0], op_lo};
        hit = -1;
        for (int i = 0; i < N; i++)
            if (hit < 0 && t_v[i] && t_mac[i] == mac) hit = i;
        if (hit < 0 && op_hi[19])
            for (int i = 0; i < N; i++)
                if (hit < 0 && !t_v[i]) hit = i;
        if (hit >= 0) begin
            t_mac[hit] = mac; t_port[hit] = op_hi[17:16];
            t_st[hit] = op_hi[18]; t_v[hit] = op_hi[19];
        end
    endtask

    task automatic model_scan(input int s);
        int t;
        m_rlo = 0; m_rhi = 0;
        t = s;
        while (t < N && !t_v[t]) t++;
        sc_tgt = t;
        sc_cnt = t - s + 1;
    endtask

    always @(posedge clk) begin
        bit busy;
        logic [2:0] rise;
        if (rst) begin
            for (int i = 0; i < N; i++) begin
                t_mac[i] = 0; t_port[i] = 0; t_st[i] = 0; t_v[i] = 0;
            end
            m_wlo = 0; m_whi = 0; m_rlo = 0; m_rhi = 0; m_cmd = 0;
            mk_cnt = 0; sc_cnt = 0; sc_tgt = 0; m_cursor = 0;
            op_lo = 0; op_hi = 0;
            started = 1;
        end else begin
            busy = (mk_cnt != 0) || (sc_cnt != 0);
            if (mk_cnt != 0) begin
                mk_cnt--;
                if (mk_cnt == 0) model_make();
            end
            if (sc_cnt != 0) begin
                sc_cnt--;
                if (sc_cnt == 0) begin
                    if (sc_tgt == N) begin
                        m_rhi = 32'h0010_0000; m_cursor = N;
                    end else begin
                        m_rlo = t_mac[sc_tgt][31:0];
                        m_rhi = {11'b0, 1'b0, 1'b1, t_st[sc_tgt], t_port[sc_tgt], t_mac[sc_tgt][47:32]};
                        m_cursor = sc_tgt + 1;
                    end
                end
            end
            if (reg_wr) begin
                case (reg_addr)
                    3'd0: m_wlo = reg_wdata;
                    3'd1: m_whi = reg_wdata;
                    3'd2: begin
                        rise = reg_wdata[2:0] & ~m_cmd;
                        m_cmd = reg_wdata[2:0];
                        if (!busy) begin
                            if (rise[2]) begin
                                op_lo = m_wlo; op_hi = m_whi; mk_cnt = N + 1;
                            end else if (rise[1]) model_scan(0);
                            else if (rise[0]) model_scan(m_cursor);
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    function automatic logic [31:0] model_read(input logic [2:0] a);
        case (a)
            3'd0: return m_wlo;
            3'd1: return m_whi;
            3'd2: return {29'b0, m_cmd};
            3'd3: return {30'b0, (sc_cnt != 0), (mk_cnt != 0)};
            3'd4: return m_rlo;
            3'd5: return m_rhi;
            default: return 32'h0;
        endcase
    endfunction

    function automatic string addr_tag(input logic [2:0] a);
        case (a)
            3'd0, 3'd1: return "R2";
            3'd2: return "R11";
            3'd3: return "R3";
            3'd4, 3'd5: return "R8";
            default: return "R1";
        endcase
    endfunction

    // ---------------- checking helpers ----------------
    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h @%0t", tag, act, exp, $time);
        end
    endtask

    task automatic cyc(input logic w, input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        if (started && !rst) chk(addr_tag(reg_addr), reg_rdata, model_read(reg_addr));
        reg_wr = w; reg_addr = a; reg_wdata = d;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        cyc(1'b1, a, d);
    endtask

    task automatic peek(input logic [2:0] a, output logic [31:0] v);
        cyc(1'b0, a, 32'h0);
        #1 v = reg_rdata;
    endtask

    int last_pend;

    task automatic make_ent(input logic [47:0] mac, input logic [1:0] port, input bit st, input bit v);
        logic [31:0] r;
        wr(3'd0, mac[31:0]);
        wr(3'd1, {12'b0, v, st, port, mac[47:32]});
        wr(3'd2, 32'd4);
        last_pend = 0;
        for (int k = 0; k < 500; k++) begin
            peek(3'd3, r);
            if (!r[0]) break;
            last_pend++;
        end
        wr(3'd2, 32'd0);
    endtask

    logic [31:0] got_lo[$];
    logic [31:0] got_hi[$];
    logic [31:0] last_rhi;

    task automatic walk(output int n);
        logic [31:0] r, lo;
        got_lo.delete(); got_hi.delete();
        n = 0;
        wr(3'd2, 32'd2);
        wr(3'd2, 32'd0);
        for (int e = 0; e < N + 4; e++) begin
            for (int k = 0; k < 200; k++) begin
                peek(3'd5, r);
                if (r[19] || r[20]) break;
            end
            last_rhi = r;
            if (!r[19]) break;
            peek(3'd4, lo);
            got_lo.push_back(lo);
            got_hi.push_back(r);
            n++;
            wr(3'd2, 32'd1);
            wr(3'd2, 32'd0);
        end
    endtask

    localparam logic [47:0] MA = 48'h0011_2233_4455;
    localparam logic [47:0] MB = 48'h0066_7788_99AA;
    localparam logic [47:0] MC = 48'h02AB_CDEF_0123;
    localparam logic [47:0] MD = 48'h0A0B_0C0D_0E0F;
    localparam logic [47:0] ME = 48'h0F0F_0F0F_0F0F;
    localparam logic [47:0] MF = 48'h0000_0000_BEEF;
    localparam logic [47:0] MG = 48'h7777_0000_7777;

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        int n;
        bit seen;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1: reset state of every address
        for (int a = 0; a < 8; a++) begin
            peek(3'(a), r);
            chk("R1", r, 32'h0);
        end

        // R2: staging readback
        wr(3'd0, 32'hA1B2_C3D4);
        wr(3'd1, 32'h000B_1234);
        peek(3'd0, r); chk("R2", r, 32'hA1B2_C3D4);
        peek(3'd1, r); chk("R2", r, 32'h000B_1234);

        // R3, R5: three inserts fill slots 0,1,2
        make_ent(MA, 2'd1, 1'b0, 1'b1);
        chk("R3", last_pend, N + 1);
        make_ent(MB, 2'd0, 1'b0, 1'b1);
        make_ent(MC, 2'd2, 1'b1, 1'b1);
        walk(n);
        chk("R9", n, 3);
        chk("R5", got_lo[0], MA[31:0]);
        chk("R8", got_hi[0], {12'b0, 1'b1, 1'b0, 2'd1, MA[47:32]});
        chk("R5", got_lo[2], MC[31:0]);
        chk("R9", last_rhi, 32'h0010_0000);

        // R4: modify B in place
        make_ent(MB, 2'd3, 1'b1, 1'b1);
        walk(n);
        chk("R4", n, 3);
        chk("R4", got_hi[1], {12'b0, 1'b1, 1'b1, 2'd3, MB[47:32]});

        // R6: delete A
        make_ent(MA, 2'd0, 1'b0, 1'b0);
        walk(n);
        chk("R6", n, 2);
        chk("R6", got_lo[0], MB[31:0]);

        // R5: freed slot 0 reused
        make_ent(MD, 2'd2, 1'b0, 1'b1);
        walk(n);
        chk("R5", n, 3);
        chk("R5", got_lo[0], MD[31:0]);

        // R5: valid=0 with a new MAC inserts nothing
        make_ent(ME, 2'd1, 1'b1, 1'b0);
        walk(n);
        chk("R5", n, 3);

        // R10: search command during make is ignored
        wr(3'd0, MD[31:0]);
        wr(3'd1, {12'b0, 1'b1, 1'b0, 2'd2, MD[47:32]});
        wr(3'd2, 32'd4);
        wr(3'd2, 32'd2);
        for (int k = 0; k < 200; k++) begin
            peek(3'd3, r);
            if (!r[0]) break;
        end
        repeat (3) peek(3'd5, r);
        chk("R10", r, 32'h0010_0000);
        wr(3'd2, 32'd0);

        // R11: simultaneous make+first -> make only
        wr(3'd0, MF[31:0]);
        wr(3'd1, {12'b0, 1'b1, 1'b0, 2'd0, MF[47:32]});
        wr(3'd2, 32'd6);
        peek(3'd3, r);
        chk("R11", r, 32'h1);
        for (int k = 0; k < 200; k++) begin
            peek(3'd3, r);
            if (!r[0]) break;
        end
        peek(3'd5, r);
        chk("R11", r, 32'h0010_0000);
        // R11: held value starts nothing
        wr(3'd2, 32'd6);
        peek(3'd3, r); chk("R11", r, 32'h0);
        peek(3'd3, r); chk("R11", r, 32'h0);
        wr(3'd2, 32'd0);

        // R7: fill the table, then one more
        for (int i = 0; i < N - 4; i++)
            make_ent(48'h1000_0000_0000 + 48'(i), 2'(i), 1'b0, 1'b1);
        make_ent(MG, 2'd1, 1'b0, 1'b1);
        walk(n);
        chk("R7", n, N);
        seen = 0;
        foreach (got_lo[i]) if (got_lo[i] == MG[31:0]) seen = 1;
        chk("R7", 32'(seen), 32'h0);
        chk("R9", last_rhi, 32'h0010_0000);

        repeat (4) cyc(1'b0, 3'd3, 32'h0);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule